// File: doc/BRIEF.md
# Chip-Select Sequencer with Programmable Timing

This block sits beside the shift engine of a serial peripheral master and owns every chip-select line. A small configuration port holds five settings: the index of the line to drive, the idle level of each line, the select policy, and two words of delays. The engine raises a request when it has a frame to send. The sequencer drives the chosen line to its active level, waits the programmed lead time, and then grants the frame with a one-cycle start pulse. When the engine signals that the frame is finished, the sequencer either waits the trail time, releases the line and enforces a quiet interval, or keeps the line asserted for the next frame.

All waits are counted in whole serial-clock periods. One cycle of the `sckTick` input marks each period. The active level of a line is the inverse of its idle-level bit, so active-low and active-high devices can share the bus. Reading back the idle-level word shows ones only in the implemented positions. Software can therefore write all ones and read the word back to count the lines.

Top module: `cs_sequencer`

## Requirements
- R1: After reset, the idle-level word (address 1) reads back with ones in bits NUM_CS-1:0 and zeros above. The line index (address 0) and the policy (address 2) read 0. Delay word A (address 3) reads 0x00010001: lead time in bits 7:0 and trail time in bits 23:16. Delay word B (address 4) reads 0x00000001: quiet time in bits 7:0 and hold gap in bits 23:16. The upper bits of the idle-level word always read as zero, whatever is written.
- R2: When no frame is in progress, each `csOut` bit equals its idle-level bit.
- R3: In auto policy (code 0), a request drives the selected line to the inverse of its idle bit on the next cycle, and all other lines keep their idle level. `frameGo` pulses in the cycle in which the lead count reaches its programmed value.
- R4: Outside off policy, `frameGo` is never high unless the selected line is in its asserted phase.
- R5: In auto policy, after `frameDone` the line stays asserted for the trail count of serial periods and is then released.
- R6: After a release, no new assertion begins until the quiet count of serial periods has elapsed.
- R7: In hold policy (code 2), the line stays asserted after a frame. The next frame is granted after the hold-gap count has elapsed and a request is present, with no release in between.
- R8: A held line is released when the policy leaves hold, or after any write to the line index or the idle-level word. The release goes through the trail count and then the quiet count.
- R9: In off policy (code 3), every line stays at its idle level, and a request is granted on the same cycle without delays.
- R10: A line index of NUM_CS or above asserts no line, but frames are still sequenced and granted.
- R11: Policy code 1 behaves exactly like auto policy.
- R12: A count advances only on cycles with `sckTick` high. A programmed value of zero means the phase lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration word select (0 index, 1 idle level, 2 policy, 3 delay A, 4 delay B) |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Read-back of the word selected by cfgAddr |
| sckTick | input | 1 | One-cycle pulse per serial-clock period |
| frameReq | input | 1 | Engine has a frame waiting |
| frameGo | output | 1 | One-cycle grant to start the frame |
| frameDone | input | 1 | One-cycle pulse at the end of a frame |
| csOut | output | NUM_CS | Chip-select lines |

## Verification
The bench builds the block with four lines and 8-bit delay fields. With four lines, the masking of bits 31:4 in the idle-level read-back can be observed, and an out-of-range index such as 7 can be written. The serial tick arrives every third cycle, so each delay phase covers several clock cycles per count. Programmed values of zero, one and several periods show whether a count stops at its limit. A behavioural model runs through auto, hold, off and the spare policy code, including mid-hold releases caused by writes to the index, to the idle level and to the policy.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

  localparam int ID_W = 5;

  localparam logic [1:0] MODE_AUTO = 2'd0;
  localparam logic [1:0] MODE_HOLD = 2'd2;
  localparam logic [1:0] MODE_OFF  = 2'd3;

  localparam logic [2:0] ADDR_ID   = 3'd0;
  localparam logic [2:0] ADDR_DEF  = 3'd1;
  localparam logic [2:0] ADDR_MODE = 3'd2;
  localparam logic [2:0] ADDR_DLYA = 3'd3;
  localparam logic [2:0] ADDR_DLYB = 3'd4;

  typedef enum logic [1:0] {
    DLY_LEAD  = 2'd0,
    DLY_TRAIL = 2'd1,
    DLY_QUIET = 2'd2,
    DLY_GAP   = 2'd3
  } dlySel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    clrCnt;
    logic    latchSel;
    logic    csOn;
    dlySel_e dlySel;
  } ctlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic cntDone;
    logic cfgChg;
    logic holdMode;
    logic offMode;
  } dpStatus_t;

endpackage

// File: rtl/cs_seq_dp.sv
module cs_seq_dp
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              sckTick,
  input  ctlStrobe_t        ctl,
  output dpStatus_t         stat,
  output logic [NUM_CS-1:0] csOut
);

  logic [ID_W-1:0]   idReg;
  logic [NUM_CS-1:0] defReg;
  logic [1:0]        modeReg;
  logic [DLY_W-1:0]  dlyLead, dlyTrail, dlyQuiet, dlyGap;
  logic [DLY_W-1:0]  cnt, selDly;
  logic [ID_W-1:0]   snapId;
  logic [NUM_CS-1:0] snapDef, selMask;
  logic              relPend, selHit, offMode;

  assign selHit = cfgWrEn && ((cfgAddr == ADDR_ID) || (cfgAddr == ADDR_DEF));

  // configuration words
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg    <= '0;
      defReg   <= '1;
      modeReg  <= MODE_AUTO;
      dlyLead  <= DLY_W'(1);
      dlyTrail <= DLY_W'(1);
      dlyQuiet <= DLY_W'(1);
      dlyGap   <= '0;
    end else if (cfgWrEn) begin
      unique case (cfgAddr)
        ADDR_ID:   idReg   <= cfgWrData[ID_W-1:0];
        ADDR_DEF:  defReg  <= cfgWrData[NUM_CS-1:0];
        ADDR_MODE: modeReg <= cfgWrData[1:0];
        ADDR_DLYA: begin
          dlyLead  <= cfgWrData[DLY_W-1:0];
          dlyTrail <= cfgWrData[16 +: DLY_W];
        end
        ADDR_DLYB: begin
          dlyQuiet <= cfgWrData[DLY_W-1:0];
          dlyGap   <= cfgWrData[16 +: DLY_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cfgRdData = '0;
    unique case (cfgAddr)
      ADDR_ID:   cfgRdData[ID_W-1:0]   = idReg;
      ADDR_DEF:  cfgRdData[NUM_CS-1:0] = defReg;
      ADDR_MODE: cfgRdData[1:0]        = modeReg;
      ADDR_DLYA: begin
        cfgRdData[DLY_W-1:0]  = dlyLead;
        cfgRdData[16 +: DLY_W] = dlyTrail;
      end
      ADDR_DLYB: begin
        cfgRdData[DLY_W-1:0]  = dlyQuiet;
        cfgRdData[16 +: DLY_W] = dlyGap;
      end
      default: cfgRdData = '0;
    endcase
  end

  // snapshot of the selection at frame start, pending-release flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapId  <= '0;
      snapDef <= '1;
      relPend <= 1'b0;
    end else if (ctl.latchSel) begin
      snapId  <= idReg;
      snapDef <= defReg;
      relPend <= 1'b0;
    end else if (selHit) begin
      relPend <= 1'b1;
    end
  end

  // delay counter in serial periods
  always_comb begin
    unique case (ctl.dlySel)
      DLY_LEAD:  selDly = dlyLead;
      DLY_TRAIL: selDly = dlyTrail;
      DLY_QUIET: selDly = dlyQuiet;
      default:   selDly = dlyGap;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          cnt <= '0;
    else if (ctl.clrCnt)                cnt <= '0;
    else if (sckTick && cnt != selDly)  cnt <= cnt + DLY_W'(1);
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
    assign selMask[i] = (snapId == ID_W'(i));
  end

  assign offMode = (modeReg == MODE_OFF);
  assign csOut   = (ctl.csOn && !offMode) ? (snapDef ^ selMask) : defReg;

  assign stat.cntDone  = (cnt == selDly);
  assign stat.cfgChg   = relPend;
  assign stat.holdMode = (modeReg == MODE_HOLD);
  assign stat.offMode  = offMode;

  assert_cnt_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clrCnt && !sckTick) |=> $stable(cnt));

  assert_one_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.csOn && !offMode && (snapId < ID_W'(NUM_CS))) |-> ($countones(csOut ^ snapDef) == 1));

  assert_release_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (selHit && !ctl.latchSel) |=> stat.cfgChg);

endmodule

// File: rtl/cs_seq_ctl.sv
module cs_seq_ctl
  import cs_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameReq,
  input  logic       frameDone,
  input  dpStatus_t  stat,
  output ctlStrobe_t ctl,
  output logic       frameGo
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_RUN, ST_TRAIL, ST_QUIET, ST_GAP, ST_HELD
  } state_e;

  state_e st, nxt;
  logic   go, latch, csOn;
  dlySel_e dsel;

  always_comb begin
    nxt   = st;
    go    = 1'b0;
    latch = 1'b0;
    dsel  = DLY_LEAD;
    unique case (st)
      ST_IDLE: if (frameReq) begin
        latch = 1'b1;
        if (stat.offMode) begin nxt = ST_RUN; go = 1'b1; end
        else nxt = ST_LEAD;
      end
      ST_LEAD: begin
        dsel = DLY_LEAD;
        if (stat.cntDone) begin nxt = ST_RUN; go = 1'b1; end
      end
      ST_RUN: if (frameDone) begin
        if (stat.holdMode)     nxt = ST_GAP;
        else if (stat.offMode) nxt = ST_IDLE;
        else                   nxt = ST_TRAIL;
      end
      ST_TRAIL: begin
        dsel = DLY_TRAIL;
        if (stat.cntDone) nxt = ST_QUIET;
      end
      ST_QUIET: begin
        dsel = DLY_QUIET;
        if (stat.cntDone) nxt = ST_IDLE;
      end
      ST_GAP: begin
        dsel = DLY_GAP;
        if (stat.cntDone) nxt = ST_HELD;
      end
      ST_HELD: begin
        if (!stat.holdMode || stat.cfgChg) nxt = ST_TRAIL;
        else if (frameReq) begin nxt = ST_RUN; go = 1'b1; end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  assign csOn = (st == ST_LEAD) || (st == ST_RUN) || (st == ST_TRAIL) ||
                (st == ST_GAP)  || (st == ST_HELD);

  assign ctl.clrCnt   = (nxt != st);
  assign ctl.latchSel = latch;
  assign ctl.csOn     = csOn;
  assign ctl.dlySel   = dsel;
  assign frameGo      = go;

  assert_go_with_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (frameGo && !stat.offMode) |-> csOn);

  assert_done_leaves_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUN && frameDone) |=> (st != ST_RUN));

  assert_hold_stays_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_HELD && stat.holdMode && !stat.cfgChg && !frameReq) |=> (st == ST_HELD));

endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              sckTick,
  input  logic              frameReq,
  output logic              frameGo,
  input  logic              frameDone,
  output logic [NUM_CS-1:0] csOut
);

  ctlStrobe_t ctl;
  dpStatus_t  stat;

  cs_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .frameReq(frameReq), .frameDone(frameDone),
    .stat(stat), .ctl(ctl), .frameGo(frameGo)
  );

  cs_seq_dp #(.NUM_CS(NUM_CS), .DLY_W(DLY_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .sckTick(sckTick),
    .ctl(ctl), .stat(stat), .csOut(csOut)
  );

endmodule

// File: tb/cs_sequencer_bench.sv
`timescale 1ns/1ps
module cs_sequencer_bench;
  localparam int N = 4;
  localparam int FRM = 4;

  logic clk = 0, rstN = 0;
  logic cfgWrEn = 0;
  logic [2:0] cfgAddr = 0;
  logic [31:0] cfgWrData = 0, cfgRdData;
  logic sckTick = 0, frameDone = 0, frameGo;
  logic [N-1:0] csOut;
  int pend = 0, busy = 0, goCount = 0, tickDiv = 0;
  bit goSeen = 0;
  logic frameReq;
  int checks = 0, errors = 0;

  assign frameReq = (pend > 0);
  always #5 clk = ~clk;

  cs_sequencer #(.NUM_CS(N), .DLY_W(8)) u_cs_sequencer (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .sckTick(sckTick),
    .frameReq(frameReq), .frameGo(frameGo), .frameDone(frameDone), .csOut(csOut)
  );

  // behavioural reference: phases 0 idle,1 lead,2 run,3 trail,4 quiet,5 gap,6 held
  int mPh, mCnt, mId, mLead, mTrail, mQuiet, mGap, sId;
  logic [N-1:0] mDef, sDef;
  logic [1:0] mMode;
  bit mRel;

  function automatic int phDelay(int ph);
    case (ph)
      3: return mTrail;
      4: return mQuiet;
      5: return mGap;
      default: return mLead;
    endcase
  endfunction

  function automatic bit expGo();
    bit done = (mCnt == phDelay(mPh));
    case (mPh)
      0: return frameReq && (mMode == 2'd3);
      1: return done;
      6: return (mMode == 2'd2) && !mRel && frameReq;
      default: return 0;
    endcase
  endfunction

  function automatic logic [N-1:0] expCs();
    bit on = (mPh == 1) || (mPh == 2) || (mPh == 3) || (mPh == 5) || (mPh == 6);
    logic [N-1:0] m = '0;
    if (sId < N) m[sId] = 1'b1;
    if (on && mMode != 2'd3) return sDef ^ m;
    return mDef;
  endfunction

  function automatic string tagOf();
    if (mMode == 2'd1) return "R11";
    if (mMode == 2'd3) return "R9";
    if (sId >= N && mPh != 0 && mPh != 4) return "R10";
    if (phDelay(mPh) == 0 && (mPh == 1 || mPh == 3 || mPh == 4)) return "R12";
    case (mPh)
      0: return "R2";
      1, 2: return "R3";
      3: return "R5";
      4: return "R6";
      default: return (mRel || mMode != 2'd2) ? "R8" : "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; mId = 0; mDef = '1; mMode = 0;
      mLead = 1; mTrail = 1; mQuiet = 1; mGap = 0; sId = 0; sDef = '1; mRel = 0;
    end else begin
      int nph;
      bit done, latch;
      done = (mCnt == phDelay(mPh));
      nph = mPh; latch = 0;
      case (mPh)
        0: if (frameReq) begin latch = 1; nph = (mMode == 2'd3) ? 2 : 1; end
        1: if (done) nph = 2;
        2: if (frameDone) nph = (mMode == 2'd2) ? 5 : (mMode == 2'd3) ? 0 : 3;
        3: if (done) nph = 4;
        4: if (done) nph = 0;
        5: if (done) nph = 6;
        6: if (mMode != 2'd2 || mRel) nph = 3; else if (frameReq) nph = 2;
        default: nph = 0;
      endcase
      if (nph != mPh) mCnt = 0;
      else if (sckTick && !done) mCnt = mCnt + 1;
      if (latch) begin sId = mId; sDef = mDef; mRel = 0; end
      else if (cfgWrEn && (cfgAddr == 0 || cfgAddr == 1)) mRel = 1;
      if (cfgWrEn) case (cfgAddr)
        0: mId = int'(cfgWrData[4:0]);
        1: mDef = cfgWrData[N-1:0];
        2: mMode = cfgWrData[1:0];
        3: begin mLead = int'(cfgWrData[7:0]); mTrail = int'(cfgWrData[23:16]); end
        4: begin mQuiet = int'(cfgWrData[7:0]); mGap = int'(cfgWrData[23:16]); end
        default: ;
      endcase
      mPh = nph;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(csOut === expCs(), tagOf(), 32'(csOut), 32'(expCs()));
      chk(frameGo === expGo(), "R4", 32'(frameGo), 32'(expGo()));
      goSeen = frameGo;
      if (frameGo) goCount++;
    end
  end

  // serial tick and frame engine
  always @(posedge clk) begin
    #1;
    tickDiv = (tickDiv == 2) ? 0 : tickDiv + 1;
    sckTick = (tickDiv == 0);
    frameDone = 0;
    if (busy > 0) begin busy--; if (busy == 0) frameDone = 1; end
    if (goSeen) begin busy = FRM; if (pend > 0) pend--; goSeen = 0; end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #2; cfgWrEn = 1; cfgAddr = a; cfgWrData = d;
    @(posedge clk); #2; cfgWrEn = 0;
  endtask

  task automatic rdChk(logic [2:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #2; cfgAddr = a;
    @(negedge clk); chk(cfgRdData === exp, tag, cfgRdData, exp);
  endtask

  task automatic frames(int n, int wait_cyc);
    @(posedge clk); #2; pend = pend + n;
    repeat (wait_cyc) @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int g0;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // R1 reset values and implemented-line probe
    rdChk(3'd0, 32'h0, "R1");
    rdChk(3'd1, 32'h0000000F, "R1");
    rdChk(3'd2, 32'h0, "R1");
    rdChk(3'd3, 32'h00010001, "R1");
    rdChk(3'd4, 32'h00000001, "R1");
    @(negedge clk); chk(csOut === 4'hF, "R2", 32'(csOut), 32'hF);
    wr(3'd1, 32'h0); wr(3'd1, 32'hFFFFFFFF);
    rdChk(3'd1, 32'h0000000F, "R1");
    // R3 R5 R6 auto policy, line 1
    wr(3'd0, 32'd1);
    frames(3, 150);
    // longer delays
    wr(3'd3, 32'h00020003); wr(3'd4, 32'h00000004);
    frames(2, 150);
    // R12 zero delays
    wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    frames(2, 80);
    // R7 hold policy with gap 2
    wr(3'd3, 32'h00010001); wr(3'd4, 32'h00020001);
    wr(3'd2, 32'd2);
    frames(2, 100);
    @(negedge clk); chk(csOut === 4'b1101, "R7", 32'(csOut), 32'hD);
    // R8 release by index write
    wr(3'd0, 32'd2);
    repeat (40) @(posedge clk);
    @(negedge clk); chk(csOut === 4'hF, "R8", 32'(csOut), 32'hF);
    frames(1, 60);
    @(negedge clk); chk(csOut === 4'b1011, "R7", 32'(csOut), 32'hB);
    // R8 release by idle-level write
    wr(3'd1, 32'hF);
    repeat (40) @(posedge clk);
    @(negedge clk); chk(csOut === 4'hF, "R8", 32'(csOut), 32'hF);
    frames(1, 60);
    // R8 release by leaving hold
    wr(3'd2, 32'd0);
    repeat (40) @(posedge clk);
    @(negedge clk); chk(csOut === 4'hF, "R8", 32'(csOut), 32'hF);
    // R9 off policy
    wr(3'd2, 32'd3);
    g0 = goCount;
    frames(2, 60);
    chk(goCount - g0 == 2, "R9", 32'(goCount - g0), 32'd2);
    // R10 index out of range
    wr(3'd2, 32'd0); wr(3'd0, 32'd7);
    g0 = goCount;
    frames(1, 60);
    chk(goCount - g0 == 1, "R10", 32'(goCount - g0), 32'd1);
    // R11 spare code, active-high line 1
    wr(3'd2, 32'd1); wr(3'd0, 32'd1); wr(3'd1, 32'h5);
    frames(2, 150);
    @(negedge clk); chk(csOut === 4'h5, "R2", 32'(csOut), 32'h5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule